// File: doc/BRIEF.md
# Programmable Pixel Clock Divider Chain

This block derives a pixel clock from one of two fast source clocks, both of which reach it as single-cycle enables on a common system clock. A 14-bit configuration word selects the source and sets a post-scaler of 1, 2 or 4. A 4-bit modulus code then sets a divider whose moduli form the sparse set 3, 4, 5, 6, 8, 10, 12, 16, 20. A fourth post-scaler setting is a test mode. In it, one configuration bit drives the pixel clock output directly.

The divider is a prescale stage of 1, 2 or 4 (code bits 3:2) followed by a base counter of 3, 4, 4 or 5 (code bits 1:0), so a modulus can have two codes. The output is a level `pclk_o` with near-even duty and a pulse `pclk_tick` marking the end of each pixel period. A word is applied with `cfg_load`. Loading restarts every counter. Reserved fields are checked on each load, and a mismatch is reported on `cfg_error` while the word is still applied.

Top module: `pixclk_chain`

## Requirements
- R1: After reset the configuration is word 0x02A1: modulus code 0001 (divide by 4), reference source, post-scaler 1. `cfg_error` is 0 and `pclk_o` is 1.
- R2: The modulus code is bits [3:0]. Codes 0000..0111 give 3,4,4,5,6,8,8,10. When bit 3 is 1, bit 2 is ignored and bits [1:0] = 00,01,10,11 give 12,16,16,20.
- R3: Bit [7] selects the source: 1 counts `ref_en` cycles, 0 counts `pll_en` cycles. The unselected enable has no effect on the outputs.
- R4: Bits [13:12] = 00, 01, 10 set a post-scaler of 1, 2, 4. Consecutive `pclk_tick` pulses are then exactly N×S selected-source ticks apart, and each pulse is a one-cycle pulse in a cycle that carries a selected-source tick.
- R5: Bits [13:12] = 11 is test mode: `pclk_o` equals bit [6] of the word and `pclk_tick` stays 0.
- R6: Within each pixel period, `pclk_o` is 1 for exactly floor(N/2)×S selected-source ticks, and these come first in the period.
- R7: On a load, `cfg_error` becomes 1 if any of bits [4], [8], [11] is 1 or any of bits [5], [9] is 0, and 0 otherwise. The word is applied either way, and `cfg_error` holds until the next load.
- R8: A load restarts the counters. No `pclk_tick` occurs in the load cycle, a source tick in that cycle is dropped, and the first pulse follows exactly N×S selected-source ticks after the load cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_en | input | 1 | Reference source tick enable |
| pll_en | input | 1 | PLL source tick enable |
| cfg_load | input | 1 | Apply `cfg_word` at this edge |
| cfg_word | input | 14 | Configuration word |
| pclk_o | output | 1 | Pixel clock level |
| pclk_tick | output | 1 | One-cycle pulse at the end of each pixel period |
| cfg_error | output | 1 | Reserved-field mismatch in the last loaded word |

## Verification
A configuration load can fall in the same cycle as a selected-source tick, including the tick that would end a pixel period. The bench provokes this by driving both source enables at random, 3 in 4 cycles, while `cfg_load` is asserted. It also loads new words back to back in the middle of periods. Such a load is judged correct if no pulse appears in the load cycle, the tick in that cycle is not counted, and the first period after it measures exactly N×S ticks with the expected high count.

// File: rtl/pixclk_pkg.sv
package pixclk_pkg;
  localparam int CFG_W = 14;
  localparam int POS_W = 5;
  localparam logic [CFG_W-1:0] CFG_RESET = 14'h02A1;
  localparam logic [CFG_W-1:0] MUST_ONE  = 14'h0220;
  localparam logic [CFG_W-1:0] MUST_ZERO = 14'h0910;
  localparam int SRC_BIT = 7;
  localparam int AUX_BIT = 6;
  localparam int PS_LO   = 12;

  function automatic logic [2:0] post_factor(input logic [1:0] s);
    case (s)
      2'b01:   return 3'd2;
      2'b10:   return 3'd4;
      default: return 3'd1;
    endcase
  endfunction

  function automatic logic [2:0] pre_factor(input logic [3:0] code);
    if (code[3])      return 3'd4;
    else if (code[2]) return 3'd2;
    else              return 3'd1;
  endfunction

  function automatic logic [2:0] base_len(input logic [1:0] lo);
    case (lo)
      2'b00:   return 3'd3;
      2'b11:   return 3'd5;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic reserved_bad(input logic [CFG_W-1:0] w);
    return ((w & MUST_ONE) != MUST_ONE) || ((w & MUST_ZERO) != '0);
  endfunction
endpackage

// File: rtl/pixclk_cfg.sv
module pixclk_cfg
  import pixclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CFG_W-1:0] word_in,
  output logic [CFG_W-1:0] word_q,
  output logic             err_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= CFG_RESET;
      err_q  <= 1'b0;
    end else if (load) begin
      word_q <= word_in;
      err_q  <= reserved_bad(word_in);
    end
  end

  p_err_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(err_q));
  p_word_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(word_q));
endmodule

// File: rtl/pixclk_post.sv
module pixclk_post
  import pixclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       src_tick,
  input  logic [1:0] sel,
  output logic       post_tick
);
  logic [1:0] cnt;
  logic [2:0] fac;

  assign fac       = post_factor(sel);
  assign post_tick = src_tick && !restart && (cnt == 2'(fac - 3'd1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (restart)          cnt <= '0;
    else if (src_tick)         cnt <= post_tick ? 2'd0 : cnt + 2'd1;
  end

  p_post_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, cnt} < fac);
  p_post_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    post_tick |-> src_tick);
endmodule

// File: rtl/pixclk_moddiv.sv
module pixclk_moddiv
  import pixclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       step,
  input  logic [3:0] code,
  output logic       wrap,
  output logic       level
);
  logic [1:0]       pre_cnt;
  logic [2:0]       base_cnt;
  logic [2:0]       pre, base;
  logic             pre_last, base_last;
  logic [POS_W-1:0] pos, half;

  assign pre       = pre_factor(code);
  assign base      = base_len(code[1:0]);
  assign pre_last  = ({1'b0, pre_cnt} == pre - 3'd1);
  assign base_last = (base_cnt == base - 3'd1);
  assign wrap      = step && pre_last && base_last;
  assign pos       = POS_W'(base_cnt) * POS_W'(pre) + POS_W'(pre_cnt);
  assign half      = (POS_W'(pre) * POS_W'(base)) >> 1;
  assign level     = (pos < half);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      base_cnt <= '0;
    end else if (restart) begin
      pre_cnt  <= '0;
      base_cnt <= '0;
    end else if (step) begin
      if (pre_last) begin
        pre_cnt  <= '0;
        base_cnt <= base_last ? 3'd0 : base_cnt + 3'd1;
      end else begin
        pre_cnt <= pre_cnt + 2'd1;
      end
    end
  end

  p_count_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, pre_cnt} < pre) && (base_cnt < base));
  p_rise_on_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(level) |-> $past(wrap || restart));
  p_restart_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (pos == '0));
endmodule

// File: rtl/pixclk_chain.sv
module pixclk_chain
  import pixclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_en,
  input  logic             pll_en,
  input  logic             cfg_load,
  input  logic [CFG_W-1:0] cfg_word,
  output logic             pclk_o,
  output logic             pclk_tick,
  output logic             cfg_error
);
  logic [CFG_W-1:0] word_q;
  logic             sel_src_tick;
  logic             post_tick;
  logic             div_wrap, div_level;
  logic             test_mode;

  pixclk_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .load(cfg_load), .word_in(cfg_word),
    .word_q(word_q), .err_q(cfg_error)
  );

  assign sel_src_tick = word_q[SRC_BIT] ? ref_en : pll_en;
  assign test_mode    = (word_q[PS_LO+1:PS_LO] == 2'b11);

  pixclk_post u_post (
    .clk(clk), .rst_n(rst_n), .restart(cfg_load), .src_tick(sel_src_tick),
    .sel(word_q[PS_LO+1:PS_LO]), .post_tick(post_tick)
  );

  pixclk_moddiv u_div (
    .clk(clk), .rst_n(rst_n), .restart(cfg_load), .step(post_tick),
    .code(word_q[3:0]), .wrap(div_wrap), .level(div_level)
  );

  assign pclk_o    = test_mode ? word_q[AUX_BIT] : div_level;
  assign pclk_tick = div_wrap && !test_mode;

  p_load_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |-> !pclk_tick);
  p_test_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |-> !pclk_tick);
  p_tick_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pclk_tick |-> sel_src_tick);
  p_tick_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pclk_tick && !cfg_load |=> !pclk_tick || (word_q[3:0] == 4'b0000 && word_q[PS_LO+1:PS_LO] == 2'b00));
endmodule

// File: tb/pixclk_chain_test.sv
module pixclk_chain_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_en = 1'b0, pll_en = 1'b0, cfg_load = 1'b0;
  logic [13:0] cfg_word = '0;
  logic        pclk_o, pclk_tick, cfg_error;

  int tests = 0;
  int fails = 0;
  logic [13:0] cur;

  pixclk_chain uut (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .pll_en(pll_en),
    .cfg_load(cfg_load), .cfg_word(cfg_word),
    .pclk_o(pclk_o), .pclk_tick(pclk_tick), .cfg_error(cfg_error)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int exp_mod(input logic [3:0] c);
    int tbl[8] = '{3, 4, 4, 5, 6, 8, 8, 10};
    if (c[3]) return (c[1:0] == 2'b00) ? 12 : (c[1:0] == 2'b11) ? 20 : 16;
    return tbl[c[2:0]];
  endfunction

  function automatic int exp_post(input logic [1:0] s);
    return 1 << s;
  endfunction

  function automatic logic exp_err(input logic [13:0] w);
    return w[4] | w[8] | w[11] | !w[5] | !w[9];
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive_src();
    ref_en = ($urandom % 4) != 0;
    pll_en = ($urandom % 4) != 0;
  endtask

  task automatic load(input logic [13:0] w);
    @(negedge clk);
    cfg_load = 1'b1; cfg_word = w; drive_src();
    #1 chk(!pclk_tick, "R8 tick in load cycle", pclk_tick, 0);
    cur = w;
    @(negedge clk);
    cfg_load = 1'b0; drive_src();
    #1 chk(cfg_error == exp_err(w), "R7 cfg_error", cfg_error, exp_err(w));
  endtask

  // measures periods starting with the cycle already driven after load
  task automatic measure(input int periods, input logic just_loaded);
    int n = exp_mod(cur[3:0]) * exp_post(cur[13:12]);
    int hi_exp = (exp_mod(cur[3:0]) / 2) * exp_post(cur[13:12]);
    int cnt = 0, hi = 0, got = 0, guard = 0;
    logic first = just_loaded;
    while (got < periods && guard < 4000) begin
      logic sen = cur[7] ? ref_en : pll_en;
      if (sen) begin
        cnt++;
        if (pclk_o) hi++;
      end
      if (pclk_tick) begin
        if (!sen) chk(1'b0, "R3 tick without selected source", 0, 1);
        if (got > 0 || first)
          chk(cnt == n, first ? "R8 first period after load" : "R4 period R2 R3", cnt, n);
        if (got > 0 || first)
          chk(hi == hi_exp, "R6 high ticks", hi, hi_exp);
        first = 1'b0;
        got++; cnt = 0; hi = 0;
      end
      @(negedge clk); drive_src(); #1; guard++;
    end
    chk(got == periods, "R4 periods seen", got, periods);
  endtask

  function automatic logic [13:0] mkword(input logic [3:0] c, input logic [1:0] s,
                                         input logic src, input logic aux);
    logic [13:0] w = 14'h0220;
    w[3:0] = c; w[13:12] = s; w[7] = src; w[6] = aux;
    return w;
  endfunction

  initial begin
    int seed = $urandom(32'd24681);
    seed = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(cfg_error == 1'b0, "R1 cfg_error at reset", cfg_error, 0);
    chk(pclk_o == 1'b1, "R1 pclk_o at reset", pclk_o, 1);
    cur = 14'h02A1;
    @(negedge clk); drive_src(); #1;
    measure(3, 1'b0);

    // directed sweep: all codes, scalers, sources
    for (int c = 0; c < 16; c++)
      for (int s = 0; s < 3; s++)
        for (int src = 0; src < 2; src++) begin
          load(mkword(4'(c), 2'(s), src[0], 1'b0));
          measure(2, 1'b1);
        end

    // test mode
    for (int a = 0; a < 4; a++) begin
      load(mkword(4'($urandom), 2'b11, 1'($urandom), a[0]));
      for (int k = 0; k < 20; k++) begin
        chk(pclk_o == a[0], "R5 pclk_o follows aux", pclk_o, a[0]);
        chk(!pclk_tick, "R5 no tick in test mode", pclk_tick, 0);
        @(negedge clk); drive_src(); #1;
      end
    end

    // random words, some with reserved faults, some reloaded mid-period
    for (int i = 0; i < 40; i++) begin
      logic [13:0] w = mkword(4'($urandom), 2'($urandom % 3), 1'($urandom), 1'($urandom));
      if ($urandom % 3 == 0) w[4 + ($urandom % 8)] = ~w[4 + ($urandom % 8)];
      w[6] = 1'($urandom); w[7] = 1'($urandom);
      w[10] = 1'($urandom);
      load(w);
      if ($urandom % 2 == 0) begin
        repeat ($urandom % 15) begin @(negedge clk); drive_src(); #1; end
        load(w);
      end
      measure(2, 1'b1);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    fails++; tests++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule